// File: doc/BRIEF.md
# Asynchronous EPROM Read Sequencer

This block sits between a synchronous host and an asynchronous byte-wide EPROM (16-bit address, 8-bit data). It converts each read request into a timed pin sequence on the memory. The address and the active-low chip select go out together. The active-low output enable follows after a computed offset. The data bus is sampled once every access time has run out. After that, both enables are released and the bus is left idle for the float interval before the next access may start.

All memory timings are given as parameters in nanoseconds, together with the clock period. The block turns each one into a whole number of clock cycles by rounding up. The output-enable offset is rounded down, so that it never lengthens the access.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the host keeps `req_valid` and `req_addr` steady, and the request waits rather than being lost. The response side is a one-cycle `rsp_valid` pulse with no back-pressure, so the consumer must take the byte in that cycle. `rsp_data` keeps the byte until the next capture.

Top module: `eprom_rd_ctrl`

## Requirements
- R1: While and after reset, with no request taken, `mem_ce_n` and `mem_oe_n` are high, `rsp_valid` is low, `req_ready` is high and `busy` is low.
- R2: A request is accepted only on an edge with `req_valid` and `req_ready` both high. From that edge `req_ready` stays low and `busy` stays high until the float interval ends. A request held during that time is accepted later. Every accepted address produces exactly one response, and responses come back in request order.
- R3: On the accepting edge, `mem_addr` takes the request address and `mem_ce_n` falls. `mem_addr` does not change while `mem_ce_n` stays low.
- R4: `mem_oe_n` falls OE_OFF cycles after `mem_ce_n` falls, where OE_OFF = floor((T_ACC_NS - T_OE_NS) / CLK_PERIOD_NS), and never less than 0. `mem_oe_n` is never low while `mem_ce_n` is high.
- R5: The byte on `mem_dq` is captured on the edge WAIT cycles after the accepting edge. WAIT is the largest of three values: ceil(T_ACC_NS/period), ceil(T_CE_NS/period) and OE_OFF + ceil(T_OE_NS/period). `rsp_valid` is high for exactly that one cycle and carries the captured byte.
- R6: `mem_ce_n` and `mem_oe_n` both return high on the capture edge, so they are high in the cycle where `rsp_valid` is high.
- R7: `req_ready` rises DF cycles after the capture edge, where DF = ceil(T_DF_NS/period) and at least 1. At least T_DF_NS passes between the release of the enables and the next fall of `mem_ce_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host has a read request |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_addr | input | 16 | Byte address of the request |
| busy | output | 1 | An access or its float interval is in progress |
| rsp_valid | output | 1 | One-cycle pulse marking a returned byte |
| rsp_data | output | 8 | Returned byte, held until the next capture |
| mem_addr | output | 16 | Address pins to the memory |
| mem_ce_n | output | 1 | Chip select to the memory, active low |
| mem_oe_n | output | 1 | Output enable to the memory, active low |
| mem_dq | input | 8 | Data pins from the memory |

## Verification
Suppose the wait counter or the state register is wrong. If capture comes too early, the byte is taken while the memory model still drives unknowns. That bad byte appears at `rsp_data` on the very pulse in question, or the pulse comes on the wrong cycle. A wrong output-enable offset shows up as a cycle mismatch as soon as the first `mem_oe_n` fall happens. If the float count is too short, `req_ready` rises early, or the next chip-select fall lands inside the float window. Either way it is caught within one access of the fault.

// File: rtl/eprom_rd_pkg.sv
package eprom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FLOAT  = 2'd2
  } rd_state_e;

  // round a nanosecond figure up to whole clock cycles
  function automatic int cyc_ceil(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eprom_rd_seq.sv
module eprom_rd_seq
  import eprom_rd_pkg::*;
#(
  parameter int WAIT_CYC = 7,
  parameter int OE_OFF   = 2,
  parameter int DF_CYC   = 3,
  parameter int CNT_W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic oe_go,
  output logic capture
);

  localparam logic [CNT_W-1:0] WAIT_V = CNT_W'(WAIT_CYC);
  localparam logic [CNT_W-1:0] OFF_V  = CNT_W'(OE_OFF);
  localparam logic [CNT_W-1:0] DF_V   = CNT_W'(DF_CYC);

  rd_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;

  // cnt holds the number of edges since the state was entered, minus one
  assign cnt_nx  = cnt + 1'b1;
  assign idle    = (state == ST_IDLE);
  assign oe_go   = (state == ST_ACCESS) && (cnt_nx == OFF_V);
  assign capture = (state == ST_ACCESS) && (cnt_nx == WAIT_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (capture) begin
            state <= ST_FLOAT;
            cnt   <= '0;
          end else begin
            cnt <= cnt_nx;
          end
        end
        ST_FLOAT: begin
          if (cnt_nx >= DF_V) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt_nx;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  AST_ACCESS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACCESS) |-> (cnt < WAIT_V)); // R5

  AST_FLOAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FLOAT) |-> (cnt < DF_V)); // R7

  AST_FLOAT_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (state == ST_FLOAT)); // R7

endmodule

// File: rtl/eprom_rd_pins.sv
module eprom_rd_pins #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int OE_OFF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              oe_go,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              ce_n,
  output logic              oe_n,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  logic oe_set;

  // zero offset: output enable goes low with chip select
  generate
    if (OE_OFF == 0) begin : g_oe_now
      assign oe_set = start;
      logic unused_go;
      assign unused_go = oe_go;
    end else begin : g_oe_late
      assign oe_set = oe_go;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= capture;
      if (start) begin
        mem_addr <= addr_in;
        ce_n     <= 1'b0;
      end else if (capture) begin
        ce_n <= 1'b1;
      end
      if (capture)     oe_n <= 1'b1;
      else if (oe_set) oe_n <= 1'b0;
      if (capture) rsp_data <= dq;
    end
  end

  AST_OE_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ce_n); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && $past(!ce_n)) |-> $stable(mem_addr)); // R3

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R5

  AST_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (ce_n && oe_n)); // R6

endmodule

// File: rtl/eprom_rd_ctrl.sv
module eprom_rd_ctrl
  import eprom_rd_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_ACC_NS      = 55,
  parameter int T_CE_NS       = 55,
  parameter int T_OE_NS       = 35,
  parameter int T_DF_NS       = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  input  logic [DATA_W-1:0] mem_dq
);

  localparam int ACC_CYC  = imax(1, cyc_ceil(T_ACC_NS, CLK_PERIOD_NS));
  localparam int CE_CYC   = imax(1, cyc_ceil(T_CE_NS, CLK_PERIOD_NS));
  localparam int OE_CYC   = imax(1, cyc_ceil(T_OE_NS, CLK_PERIOD_NS));
  localparam int DF_CYC   = imax(1, cyc_ceil(T_DF_NS, CLK_PERIOD_NS));
  localparam int OE_OFF   = imax(0, (T_ACC_NS - T_OE_NS) / CLK_PERIOD_NS);
  localparam int WAIT_CYC = imax(imax(ACC_CYC, CE_CYC), OE_OFF + OE_CYC);
  localparam int CNT_W    = $clog2(WAIT_CYC + DF_CYC + 2) + 1;

  logic idle, start, oe_go, capture;

  assign start     = req_valid && idle;
  assign req_ready = idle;
  assign busy      = !idle;

  eprom_rd_seq #(
    .WAIT_CYC (WAIT_CYC),
    .OE_OFF   (OE_OFF),
    .DF_CYC   (DF_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .idle    (idle),
    .oe_go   (oe_go),
    .capture (capture)
  );

  eprom_rd_pins #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OE_OFF (OE_OFF)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .addr_in   (req_addr),
    .oe_go     (oe_go),
    .capture   (capture),
    .dq        (mem_dq),
    .mem_addr  (mem_addr),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  // pin-level age counters used only by the timing properties below
  logic [CNT_W-1:0] sel_age;
  logic [CNT_W-1:0] rel_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_age <= '0;
      rel_age <= CNT_W'(DF_CYC);
    end else begin
      sel_age <= mem_ce_n ? '0 : sel_age + 1'b1;
      if (!mem_ce_n)                       rel_age <= '0;
      else if (rel_age < CNT_W'(DF_CYC))   rel_age <= rel_age + 1'b1;
    end
  end

  AST_WAIT_MET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (sel_age == CNT_W'(WAIT_CYC))); // R5

  AST_OE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (sel_age == CNT_W'(OE_OFF))); // R4

  AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> (rel_age >= CNT_W'(DF_CYC))); // R7

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && !rsp_valid)); // R2

endmodule

// File: tb/eprom_rd_ctrl_test.sv
`timescale 1ns/1ps
module eprom_rd_ctrl_test;

  localparam int PER    = 10;
  localparam int ACC_NS = 55;
  localparam int CE_NS  = 62;
  localparam int OE_NS  = 35;
  localparam int DF_NS  = 25;
  // expected cycle figures derived from the requirements
  localparam int EXP_OFF  = (ACC_NS - OE_NS) / PER;   // 2
  localparam int EXP_WAIT = 7;                        // max(6, 7, 2+4)
  localparam int EXP_DF   = 3;                        // ceil(25/10)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        busy;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [15:0] mem_addr;
  logic        mem_ce_n;
  logic        mem_oe_n;
  logic [7:0]  dq_drv = 'z;
  wire  [7:0]  mem_dq = dq_drv;

  always #(PER/2) clk = ~clk;

  eprom_rd_ctrl #(
    .CLK_PERIOD_NS (PER),
    .T_ACC_NS      (ACC_NS),
    .T_CE_NS       (CE_NS),
    .T_OE_NS       (OE_NS),
    .T_DF_NS       (DF_NS)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
    .busy (busy), .rsp_valid (rsp_valid), .rsp_data (rsp_data),
    .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n),
    .mem_dq (mem_dq)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return {a[3:0], a[15:12]} ^ a[11:4] ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural memory: unknown until every access time is met, unknown through float, then released
  longint t_addr = 0, t_ce = 0, t_oe = 0, t_rel = -1000;
  logic [15:0] m_prev_addr = '0;
  logic m_prev_ce = 1'b1, m_prev_oe = 1'b1;

  always @(posedge clk) begin
    #1;
    if (mem_addr !== m_prev_addr) begin
      if (!mem_ce_n && !m_prev_ce)
        check(0, "R3", "address moved while selected", mem_addr, m_prev_addr);
      t_addr = $time;
    end
    if (!mem_ce_n && m_prev_ce) begin
      t_ce = $time;
      check(($time - t_rel) >= DF_NS, "R7", "float gap ns", $time - t_rel, DF_NS);
    end
    if (!mem_oe_n && m_prev_oe) t_oe = $time;
    if ((mem_ce_n || mem_oe_n) && !(m_prev_ce || m_prev_oe)) t_rel = $time;
    if (!mem_ce_n && !mem_oe_n) begin
      if (($time + PER - t_addr) >= ACC_NS && ($time + PER - t_ce) >= CE_NS &&
          ($time + PER - t_oe) >= OE_NS)
        dq_drv = mem_byte(mem_addr);
      else
        dq_drv = 'x;
    end else if (($time - t_rel) < DF_NS) begin
      dq_drv = 'x;
    end else begin
      dq_drv = 'z;
    end
    m_prev_addr = mem_addr;
    m_prev_ce   = mem_ce_n;
    m_prev_oe   = mem_oe_n;
  end

  // scoreboard
  logic [7:0] exp_q[$];
  int         acc_q[$];
  int         sent = 0, got = 0;

  task automatic send(input logic [15:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) begin
      check(busy === 1'b1, "R2", "busy while not ready", busy, 1);
      @(negedge clk);
    end
    exp_q.push_back(mem_byte(a));
    acc_q.push_back(cyc + 1);
    sent++;
    @(posedge clk);
  endtask

  task automatic rest(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  logic mon_ce = 1'b1, mon_oe = 1'b1, mon_rdy = 1'b1;
  int   ce_fall = 0, rsp_cyc = -100;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mon_ce && !mem_ce_n) begin
        ce_fall = cyc;
        check(acc_q.size() > 0 && acc_q[acc_q.size()-1] == cyc, "R3",
              "select fall cycle", cyc, acc_q.size() > 0 ? acc_q[acc_q.size()-1] : -1);
      end
      if (mon_oe && !mem_oe_n)
        check(cyc - ce_fall == EXP_OFF, "R4", "oe offset", cyc - ce_fall, EXP_OFF);
      if (rsp_valid) begin
        rsp_cyc = cyc;
        got++;
        check(mem_ce_n && mem_oe_n, "R6", "enables released", {mem_ce_n, mem_oe_n}, 3);
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected response", rsp_data, 0);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          automatic int a = acc_q.pop_front();
          check(rsp_data === e, "R5", "data", rsp_data, e);
          check(cyc - a == EXP_WAIT, "R5", "latency", cyc - a, EXP_WAIT);
        end
      end
      if (!mon_rdy && req_ready)
        check(cyc - rsp_cyc == EXP_DF, "R7", "ready return", cyc - rsp_cyc, EXP_DF);
      mon_ce  = mem_ce_n;
      mon_oe  = mem_oe_n;
      mon_rdy = req_ready;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "R2", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(mem_ce_n && mem_oe_n && !rsp_valid && req_ready && !busy, "R1", "reset pins",
          {mem_ce_n, mem_oe_n, rsp_valid, req_ready, busy}, 5'b11010);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_oe_n && !rsp_valid && req_ready && !busy, "R1", "idle pins",
          {mem_ce_n, mem_oe_n, rsp_valid, req_ready, busy}, 5'b11010);

    send(16'h0000); rest(12);
    send(16'hFFFF); rest(12);
    send(16'h1234);
    // held back-to-back requests: valid stays high through busy
    for (int i = 0; i < 8; i++) send(16'h0100 * i + 16'h0033 + i);
    rest(2);
    send(16'h8001); rest(1);
    send(16'h7FFE); send(16'hA5A5); rest(20);
    for (int i = 0; i < 6; i++) begin
      send(16'h1000 << (i % 4));
      rest(i);
    end
    while (exp_q.size() != 0) @(negedge clk);
    rest(6);
    check(got == sent, "R2", "response count", got, sent);
    check(req_ready && !busy && mem_ce_n && mem_oe_n, "R1", "idle after traffic",
          {req_ready, busy}, 2'b10);
    finish_run();
  end

endmodule